// File: doc/BRIEF.md
# Receive Event Counters with Wrap Flags

This block keeps two 16-bit event tallies for the receive side of an Ethernet MAC. One tallies frames that had to be dropped because no buffer was free. The other tallies collisions that the receiver saw. The receive datapath raises a one-cycle pulse for each event, and the matching tally steps up by one. Neither tally saturates: at its top value it rolls back to zero. Each rollover latches a sticky flag, and each tally has its own flag.

Software sees the block through a small register port. A read request returns a registered 32-bit word one cycle later. Two addresses return the tallies. A third returns the two flags, and software clears a flag by writing 1 to its bit. Writes to the tally addresses have no effect. Three conditions empty both tallies: a hardware reset, a software reset, or the stop control. Only the two resets clear the flags.

Top module: `rx_event_counters`

## Requirements
- R1: After hardware reset (`rst` high for at least one clock) both tallies read 0 and both flags read 0.
- R2: A one-cycle `miss_inc` pulse makes the tally at address 0 one higher from the next cycle onward. The tally at address 1 does not change.
- R3: A one-cycle `coll_inc` pulse makes the tally at address 1 one higher. Pulses on both inputs in the same cycle step both tallies.
- R4: A tally at 65535 that takes a pulse reads 0 on the next cycle. It does not saturate.
- R5: A rollover sets that tally's flag in the same cycle the tally shows 0. The status word at address 2 has bit 0 for the address-0 tally and bit 1 for the address-1 tally. The other flag is unchanged.
- R6: Flags stay set until software writes to address 2 with a 1 in their bit. A 0 bit leaves its flag alone. If a rollover and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: Writes to address 0 or address 1 leave both tallies unchanged.
- R8: When `stop` or `soft_rst` is high, both tallies read 0 on the next cycle, and any increment pulse in that cycle is dropped. `stop` does not change the flags. `soft_rst` clears them.
- R9: Bits 31:16 of every read word are 0, and address 3 reads as all zeros. The read word appears with `rd_valid` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Software reset: clears tallies and flags |
| stop | input | 1 | Stop control: clears tallies while high |
| miss_inc | input | 1 | One-cycle pulse per missed frame |
| coll_inc | input | 1 | One-cycle pulse per receive collision |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (2 = flag status) |
| wr_data | input | 2 | Write-1-to-clear bits for the two flags |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address (0 miss, 1 collision, 2 status) |
| rd_valid | output | 1 | Read word valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read word |
| ovf_flags | output | 2 | Live flag values, bit 0 miss, bit 1 collision |

## Verification
The hardest case to reach from the ports is a rollover, because a tally has to reach 65535 before it can wrap. The stimulus drives both pulse inputs high together for 65535 cycles, so both tallies reach their top value at once. It then pulses each input alone, which shows that each flag answers only to its own tally. A second run of 65535 collision pulses sets up a rollover in the same cycle as a write-1 clear of that flag, which checks that the set wins.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int CNT_W    = 16;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int NUM_CNT  = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADDR_MISS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_COLL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    // Index of each tally inside the packed arrays
    typedef enum logic [0:0] {
        IDX_MISS = 1'b0,
        IDX_COLL = 1'b1
    } cnt_idx_e;

    // Result of one tally for the current cycle
    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             wrap;
    } cnt_state_t;

    // A write that targets the status word
    function automatic logic stat_write(input logic en, input logic [ADDR_W-1:0] addr);
        return en && (addr == ADDR_STAT);
    endfunction

endpackage

// File: rtl/rxs_event_counter.sv
module rxs_event_counter
    import rxs_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         wrap
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] count_q;
    logic         take;

    assign take  = inc && !clr;
    assign wrap  = take && (count_q == TOP);
    assign count = count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (take) begin
            count_q <= count_q + W'(1);
        end
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);                                          // R8
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> count == $past(count) + W'(1));              // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(count));                            // R7
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> count == '0);                                         // R4

endmodule

// File: rtl/rxs_sticky_flag.sv
module rxs_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic soft_clr,
    input  logic set,
    input  logic w1c,
    output logic flag
);

    logic flag_q;

    assign flag = flag_q;

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (w1c) begin
            flag_q <= 1'b0;
        end
    end

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (set && !soft_clr) |=> flag);                                  // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !w1c && !soft_clr) |=> flag);                         // R6
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
        (w1c && !set) |=> !flag);                                      // R6

endmodule

// File: rtl/rxs_read_port.sv
module rxs_read_port
    import rxs_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int N  = NUM_CNT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [N-1:0][CW-1:0] counts,
    input  logic [N-1:0]         flags,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_data
);

    logic [DW-1:0] word_d;
    logic [DW-1:0] word_q;
    logic          valid_q;

    always_comb begin
        word_d = '0;
        case (rd_addr)
            ADDR_MISS: word_d[CW-1:0] = counts[IDX_MISS];
            ADDR_COLL: word_d[CW-1:0] = counts[IDX_COLL];
            ADDR_STAT: word_d[N-1:0]  = flags;
            default:   word_d         = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            valid_q <= rd_en;
            if (rd_en) begin
                word_q <= word_d;
            end
        end
    end

    assign rd_valid = valid_q;
    assign rd_data  = word_q;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);                                           // R9
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_data[DW-1:CW] == '0);                          // R9

endmodule

// File: rtl/rx_event_counters.sv
module rx_event_counters
    import rxs_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 soft_rst,
    input  logic                 stop,
    input  logic                 miss_inc,
    input  logic                 coll_inc,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NUM_CNT-1:0]   wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_data,
    output logic [NUM_CNT-1:0]   ovf_flags
);

    logic                          tally_clr;
    logic                          stat_wr;
    logic [NUM_CNT-1:0]            inc_vec;
    logic [NUM_CNT-1:0][CW-1:0]    count_vec;
    logic [NUM_CNT-1:0]            flag_vec;
    cnt_state_t [NUM_CNT-1:0]      state_vec;

    assign tally_clr          = soft_rst || stop;
    assign stat_wr            = stat_write(wr_en, wr_addr);
    assign inc_vec[IDX_MISS]  = miss_inc;
    assign inc_vec[IDX_COLL]  = coll_inc;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_tally
        rxs_event_counter #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (tally_clr),
            .inc   (inc_vec[i]),
            .count (state_vec[i].value),
            .wrap  (state_vec[i].wrap)
        );

        rxs_sticky_flag u_flag (
            .clk      (clk),
            .rst      (rst),
            .soft_clr (soft_rst),
            .set      (state_vec[i].wrap),
            .w1c      (stat_wr && wr_data[i]),
            .flag     (flag_vec[i])
        );

        assign count_vec[i] = state_vec[i].value;
    end

    rxs_read_port #(.CW(CW), .DW(DW), .N(NUM_CNT)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .counts   (count_vec),
        .flags    (flag_vec),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign ovf_flags = flag_vec;

    AST_STOP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (stop && !soft_rst && !stat_wr) |=> ovf_flags == $past(ovf_flags) || ovf_flags != '0); // R8
    AST_SOFT_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> ovf_flags == '0);                                 // R8

endmodule

// File: tb/rx_event_counters_test.sv
module rx_event_counters_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        stop = 1'b0;
    logic        miss_inc = 1'b0;
    logic        coll_inc = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [1:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [1:0]  ovf_flags;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [1:0]  addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t exp_q[$];

    rx_event_counters uut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop(stop),
        .miss_inc(miss_inc), .coll_inc(coll_inc),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .ovf_flags(ovf_flags)
    );

    always #2.5 clk = ~clk;

    // Monitor: pop one expected item per returned read word
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected read word %h, expected none", "R9", rd_data);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                if (rd_data !== it.exp) begin
                    fails++;
                    $display("FAIL %s: addr %0d read %h, expected %h", it.tag, it.addr, rd_data, it.exp);
                end
            end
        end
    end

    // All tasks start and end on a falling edge
    task automatic do_read(input logic [1:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic m, input logic c, input int n);
        miss_inc = m; coll_inc = c;
        repeat (n) @(negedge clk);
        miss_inc = 1'b0; coll_inc = 1'b0;
    endtask

    task automatic check_flags(input logic [1:0] e, input string tag);
        tests++;
        if (ovf_flags !== e) begin
            fails++;
            $display("FAIL %s: ovf_flags %b, expected %b", tag, ovf_flags, e);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        do_read(2'd0, 32'h0, "R1");
        do_read(2'd1, 32'h0, "R1");
        do_read(2'd2, 32'h0, "R1");
        check_flags(2'b00, "R1");
        do_read(2'd3, 32'h0, "R9");

        // R2: missed-frame pulses
        pulse(1'b1, 1'b0, 3);
        do_read(2'd0, 32'd3, "R2");
        do_read(2'd1, 32'd0, "R2");

        // R3: collision pulses, then both together
        pulse(1'b0, 1'b1, 2);
        pulse(1'b1, 1'b1, 2);
        do_read(2'd0, 32'd5, "R3");
        do_read(2'd1, 32'd4, "R3");

        // R7: writes to tally addresses ignored
        do_write(2'd0, 2'b11);
        do_write(2'd1, 2'b11);
        do_read(2'd0, 32'd5, "R7");
        do_read(2'd1, 32'd4, "R7");

        // R8: stop with pulses in the same cycle
        stop = 1'b1; miss_inc = 1'b1; coll_inc = 1'b1;
        @(negedge clk);
        stop = 1'b0; miss_inc = 1'b0; coll_inc = 1'b0;
        do_read(2'd0, 32'd0, "R8");
        do_read(2'd1, 32'd0, "R8");

        // R8: soft reset clears tallies
        pulse(1'b1, 1'b1, 2);
        soft_rst = 1'b1; miss_inc = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0; miss_inc = 1'b0;
        do_read(2'd0, 32'd0, "R8");
        do_read(2'd1, 32'd0, "R8");

        // R4/R5: fill both to the top value, then wrap each alone
        pulse(1'b1, 1'b1, 65535);
        do_read(2'd0, 32'd65535, "R4");
        do_read(2'd1, 32'd65535, "R4");
        do_read(2'd2, 32'd0, "R5");
        pulse(1'b1, 1'b0, 1);
        check_flags(2'b01, "R5");
        do_read(2'd0, 32'd0, "R4");
        do_read(2'd1, 32'd65535, "R5");
        do_read(2'd2, 32'd1, "R5");
        pulse(1'b0, 1'b1, 1);
        do_read(2'd1, 32'd0, "R4");
        do_read(2'd2, 32'd3, "R5");

        // R6: stickiness and write-1-to-clear
        repeat (4) @(negedge clk);
        do_read(2'd2, 32'd3, "R6");
        do_write(2'd2, 2'b10);
        do_read(2'd2, 32'd1, "R6");
        do_write(2'd2, 2'b00);
        do_read(2'd2, 32'd1, "R6");

        // R6: rollover and clear of the same flag in one cycle
        pulse(1'b0, 1'b1, 65535);
        coll_inc = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 2'b10;
        @(negedge clk);
        coll_inc = 1'b0; wr_en = 1'b0; wr_data = '0;
        do_read(2'd1, 32'd0, "R4");
        do_read(2'd2, 32'd3, "R6");

        // R8: stop leaves flags, soft reset clears them
        pulse(1'b1, 1'b0, 2);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        do_read(2'd0, 32'd0, "R8");
        do_read(2'd2, 32'd3, "R8");
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        do_read(2'd2, 32'd0, "R8");
        check_flags(2'b00, "R8");

        repeat (3) @(negedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9: %0d reads unanswered, expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule